// File: doc/BRIEF.md
# Floating-Point Operand Classifier and NaN Canonicalizer

This block sits in front of a floating-point arithmetic unit. Each transfer carries one or two operands in a selected storage format (single, double, or an extended result word). The block sorts every operand into one of six classes: normal, denormal, zero, infinity, quiet NaN or signaling NaN. For each operand it also reports the implicit integer bit. When a used operand is a NaN, it flags that its substitute result must replace the arithmetic result. That substitute is always one fixed quiet NaN with an all-ones fraction and a clear sign bit. NaN payloads are never passed on.

A signaling NaN on a used operand raises an invalid-operation indication on that result. It also sets a sticky flag that software clears with a one-cycle pulse. In extended mode the 43-bit extended word is widened into a 64-bit double word, and the 21 low fraction bits are forced to zero.

The stage is a single register slice on a valid/ready stream. An input is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the slice is empty or when the downstream side takes the current result in the same cycle. While `out_valid` is high and `out_ready` is low, every result output holds its value.

Top module: `fpc_canon_top`

## Requirements
- R1: For each operand, the class output is exactly one bit of six set. The bit positions are: bit 0 normal, bit 1 denormal, bit 2 zero, bit 3 infinity, bit 4 quiet NaN, bit 5 signaling NaN.
- R2: An operand with an all-zeros exponent is zero when its fraction is all zeros and denormal otherwise. Both report an implicit bit of 0. Any other operand with an exponent that is not all ones is normal. Every operand whose exponent is not all zeros reports an implicit bit of 1.
- R3: An operand with an all-ones exponent is infinity when its fraction is zero. Otherwise it is a NaN: quiet when the fraction MSB is 1 and signaling when it is 0. The sign bit plays no part in classification.
- R4: `fmt` selects the format. The value 0 is single (sign bit 31, exponent bits 30:23, fraction bits 22:0), and bits 63:32 are ignored. The value 1 is double (sign bit 63, exponent bits 62:52, fraction bits 51:0). The value 3 behaves as 1.
- R5: `fmt`=2 is extended. Operand bits 42:0 hold the sign (bit 42), an 11-bit exponent (bits 41:31) and a 31-bit fraction (bits 30:0). The operand is widened to `{bits 42:0, 21 zero bits}` and classified as a double. `store_word` outputs the operand in its stored form, so a single operand is zero-extended to 64 bits. The stored form keeps the sign, so plus and minus zero stay distinct.
- R6: `nan_out_valid` is high exactly when a used operand is a NaN. `nan_word` then holds the canonical quiet NaN for the format: 64'h0000_0000_7FFF_FFFF (single), 64'h7FFF_FFFF_FFFF_FFFF (double) or 64'h7FFF_FFFF_FFE0_0000 (extended).
- R7: `invalid_op` is high exactly when a used operand is a signaling NaN. A quiet NaN alone never raises it.
- R8: When `two_ops` is 0, operand B is ignored for `nan_out_valid` and `invalid_op`. Its class is still reported.
- R9: `sticky_invalid` sets when an accepted input carries a used signaling NaN. It clears on a `sticky_clr` pulse. If both happen in the same cycle, the set wins. Otherwise the flag holds.
- R10: `in_ready` = !`out_valid` || `out_ready`. A result appears one cycle after acceptance and holds while it is stalled.
- R11: After reset, `out_valid` and `sticky_invalid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Slice can accept |
| fmt | input | 2 | Format: 0 single, 1 double, 2 extended |
| two_ops | input | 1 | Operand B takes part in NaN handling |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| sticky_clr | input | 1 | Clear pulse for the sticky flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Downstream accepts result |
| cls_a | output | 6 | One-hot class of operand A |
| cls_b | output | 6 | One-hot class of operand B |
| ibit_a | output | 1 | Implicit integer bit of A |
| ibit_b | output | 1 | Implicit integer bit of B |
| store_word | output | 64 | Operand A in stored (widened) form |
| nan_out_valid | output | 1 | Substitute result overrides arithmetic result |
| nan_word | output | 64 | Canonical quiet NaN for the format |
| invalid_op | output | 1 | Invalid-operation exception for this result |
| sticky_invalid | output | 1 | Sticky invalid flag |

## Verification
A wrong decode shows up on the class or implicit-bit outputs one cycle after the operand is accepted. A class vector with zero or two bits set is visible on that same result. A corrupted canonical constant or a dropped signaling-NaN condition appears in `nan_word`, `invalid_op` and `sticky_invalid` on the result of the first NaN operand. A wrong sticky state persists across idle cycles until the next clear pulse, so a check after idle cycles exposes it. Faults in the stall logic show up as a result that changes, or a `in_ready` that rises, while `out_ready` is held low.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int NCLS    = 6;
  localparam int CL_NORM = 0;
  localparam int CL_DEN  = 1;
  localparam int CL_ZERO = 2;
  localparam int CL_INF  = 3;
  localparam int CL_QNAN = 4;
  localparam int CL_SNAN = 5;

  typedef logic [1:0] fmt_t;
  localparam fmt_t FMT_SGL = 2'd0;
  localparam fmt_t FMT_DBL = 2'd1;
  localparam fmt_t FMT_EXT = 2'd2;

  typedef logic [NCLS-1:0] cls_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
#(
  parameter int W    = 64,
  parameter int SP_E = 8,
  parameter int SP_F = 23,
  parameter int DP_E = 11,
  parameter int DP_F = 52,
  parameter int PAD  = 21
) (
  input  fmt_t         fmt,
  input  logic [W-1:0] word,
  output cls_t         cls,
  output logic         ibit,
  output logic [W-1:0] wide
);
  localparam int SP_W  = 1 + SP_E + SP_F;
  localparam int EXT_W = W - PAD;

  logic is_sgl, e_zero, e_ones, f_nz, f_msb;

  always_comb begin
    case (fmt)
      FMT_SGL: wide = {{(W-SP_W){1'b0}}, word[SP_W-1:0]};
      FMT_EXT: wide = {word[EXT_W-1:0], {PAD{1'b0}}};
      default: wide = word;
    endcase
  end

  assign is_sgl = (fmt == FMT_SGL);

  always_comb begin
    if (is_sgl) begin
      e_zero = ~|wide[SP_F +: SP_E];
      e_ones = &wide[SP_F +: SP_E];
      f_nz   = |wide[SP_F-1:0];
      f_msb  = wide[SP_F-1];
    end else begin
      e_zero = ~|wide[DP_F +: DP_E];
      e_ones = &wide[DP_F +: DP_E];
      f_nz   = |wide[DP_F-1:0];
      f_msb  = wide[DP_F-1];
    end
  end

  always_comb begin
    cls          = '0;
    cls[CL_NORM] = !e_zero && !e_ones;
    cls[CL_DEN]  = e_zero && f_nz;
    cls[CL_ZERO] = e_zero && !f_nz;
    cls[CL_INF]  = e_ones && !f_nz;
    cls[CL_QNAN] = e_ones && f_nz && f_msb;
    cls[CL_SNAN] = e_ones && f_nz && !f_msb;
  end

  assign ibit = !e_zero;
endmodule

// File: rtl/fpc_canon.sv
module fpc_canon
  import fpc_pkg::*;
#(
  parameter int W    = 64,
  parameter int SP_E = 8,
  parameter int SP_F = 23,
  parameter int PAD  = 21
) (
  input  fmt_t         fmt,
  input  cls_t         cls_a,
  input  cls_t         cls_b,
  input  logic         two_ops,
  output logic [W-1:0] canon,
  output logic         nan_any,
  output logic         snan_any
);
  localparam int SP_W = 1 + SP_E + SP_F;

  always_comb begin
    case (fmt)
      FMT_SGL: canon = {{(W-SP_W){1'b0}}, 1'b0, {(SP_W-1){1'b1}}};
      FMT_EXT: canon = {1'b0, {(W-1-PAD){1'b1}}, {PAD{1'b0}}};
      default: canon = {1'b0, {(W-1){1'b1}}};
    endcase
  end

  assign nan_any  = cls_a[CL_QNAN] || cls_a[CL_SNAN] ||
                    (two_ops && (cls_b[CL_QNAN] || cls_b[CL_SNAN]));
  assign snan_any = cls_a[CL_SNAN] || (two_ops && cls_b[CL_SNAN]);
endmodule

// File: rtl/fpc_canon_top.sv
module fpc_canon_top
  import fpc_pkg::*;
#(
  parameter int W    = 64,
  parameter int SP_E = 8,
  parameter int SP_F = 23,
  parameter int DP_E = 11,
  parameter int DP_F = 52,
  parameter int PAD  = 21,
  parameter int NOPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   fmt,
  input  logic         two_ops,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sticky_clr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [5:0]   cls_a,
  output logic [5:0]   cls_b,
  output logic         ibit_a,
  output logic         ibit_b,
  output logic [W-1:0] store_word,
  output logic         nan_out_valid,
  output logic [W-1:0] nan_word,
  output logic         invalid_op,
  output logic         sticky_invalid
);
  logic [W-1:0] ops   [NOPS];
  cls_t         cls_d [NOPS];
  logic         ibit_d[NOPS];
  logic [W-1:0] wide_d[NOPS];
  logic [W-1:0] canon_d;
  logic         nan_d, snan_d, take;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_dec
    fpc_decode #(.W(W), .SP_E(SP_E), .SP_F(SP_F), .DP_E(DP_E),
                 .DP_F(DP_F), .PAD(PAD)) u_dec (
      .fmt (fmt),
      .word(ops[g]),
      .cls (cls_d[g]),
      .ibit(ibit_d[g]),
      .wide(wide_d[g])
    );
  end

  fpc_canon #(.W(W), .SP_E(SP_E), .SP_F(SP_F), .PAD(PAD)) u_canon (
    .fmt     (fmt),
    .cls_a   (cls_d[0]),
    .cls_b   (cls_d[1]),
    .two_ops (two_ops),
    .canon   (canon_d),
    .nan_any (nan_d),
    .snan_any(snan_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_a         <= '0;
      cls_b         <= '0;
      ibit_a        <= 1'b0;
      ibit_b        <= 1'b0;
      store_word    <= '0;
      nan_out_valid <= 1'b0;
      nan_word      <= '0;
      invalid_op    <= 1'b0;
    end else if (take) begin
      cls_a         <= cls_d[0];
      cls_b         <= cls_d[1];
      ibit_a        <= ibit_d[0];
      ibit_b        <= ibit_d[1];
      store_word    <= wide_d[0];
      nan_out_valid <= nan_d;
      nan_word      <= canon_d;
      invalid_op    <= snan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_invalid <= 1'b0;
    end else if (take && snan_d) begin
      sticky_invalid <= 1'b1;
    end else if (sticky_clr) begin
      sticky_invalid <= 1'b0;
    end
  end

  // wide_d[1] carries operand B's stored form, which has no output
  logic unused_b;
  assign unused_b = ^wide_d[1];
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         sticky_clr,
  input logic [5:0]   cls_a,
  input logic [5:0]   cls_b,
  input logic         ibit_a,
  input logic         nan_out_valid,
  input logic [W-1:0] nan_word,
  input logic         invalid_op,
  input logic         sticky_invalid
);
  AST_CLS_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cls_a) == 1); // R1
  AST_CLS_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cls_b) == 1); // R1
  AST_DEN_IBIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (cls_a[1] || cls_a[2]) |-> !ibit_a); // R2
  AST_CANON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && nan_out_valid |-> !nan_word[W-1] &&
      (nan_word == 64'h0000_0000_7FFF_FFFF || nan_word == 64'h7FFF_FFFF_FFFF_FFFF ||
       nan_word == 64'h7FFF_FFFF_FFE0_0000)); // R6
  AST_INV_HAS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && invalid_op |-> nan_out_valid); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_invalid && !sticky_clr |=> sticky_invalid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cls_a) && $stable(nan_word)); // R10
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready)); // R10
endmodule

bind fpc_canon_top fpc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .sticky_clr(sticky_clr), .cls_a(cls_a), .cls_b(cls_b),
  .ibit_a(ibit_a), .nan_out_valid(nan_out_valid), .nan_word(nan_word),
  .invalid_op(invalid_op), .sticky_invalid(sticky_invalid)
);

// File: tb/sim_fpc_canon_top.sv
module sim_fpc_canon_top;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, two_ops = 0, sticky_clr = 0;
  logic [1:0]  fmt = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic        out_valid, out_ready = 1;
  logic [5:0]  cls_a, cls_b;
  logic        ibit_a, ibit_b, nan_out_valid, invalid_op, sticky_invalid;
  logic [63:0] store_word, nan_word;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fpc_canon_top u0 (.*);

  typedef struct packed {
    logic [1:0]  f;
    logic [63:0] op;
    logic [5:0]  cls;
    logic        ib;
    logic [63:0] st;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{2'd0, 64'h0000_0000_3F80_0000, 6'b000001, 1'b1, 64'h0000_0000_3F80_0000},
    '{2'd0, 64'h0000_0000_0000_0001, 6'b000010, 1'b0, 64'h0000_0000_0000_0001},
    '{2'd0, 64'h0000_0000_0000_0000, 6'b000100, 1'b0, 64'h0000_0000_0000_0000},
    '{2'd0, 64'h0000_0000_8000_0000, 6'b000100, 1'b0, 64'h0000_0000_8000_0000},
    '{2'd0, 64'h0000_0000_7F80_0000, 6'b001000, 1'b1, 64'h0000_0000_7F80_0000},
    '{2'd0, 64'h0000_0000_FF80_0000, 6'b001000, 1'b1, 64'h0000_0000_FF80_0000},
    '{2'd0, 64'h0000_0000_7FC0_0000, 6'b010000, 1'b1, 64'h0000_0000_7FC0_0000},
    '{2'd0, 64'h0000_0000_FFC0_0001, 6'b010000, 1'b1, 64'h0000_0000_FFC0_0001},
    '{2'd0, 64'h0000_0000_7F80_0001, 6'b100000, 1'b1, 64'h0000_0000_7F80_0001},
    '{2'd1, 64'h3FF0_0000_0000_0000, 6'b000001, 1'b1, 64'h3FF0_0000_0000_0000},
    '{2'd1, 64'h000F_FFFF_FFFF_FFFF, 6'b000010, 1'b0, 64'h000F_FFFF_FFFF_FFFF},
    '{2'd1, 64'h7FF0_0000_0000_0000, 6'b001000, 1'b1, 64'h7FF0_0000_0000_0000},
    '{2'd1, 64'hFFF8_0000_0000_0000, 6'b010000, 1'b1, 64'hFFF8_0000_0000_0000},
    '{2'd3, 64'h7FF0_0000_0000_0001, 6'b100000, 1'b1, 64'h7FF0_0000_0000_0001},
    '{2'd2, 64'h0000_01FF_8000_0000, 6'b000001, 1'b1, 64'h3FF0_0000_0000_0000},
    '{2'd2, 64'h0000_03FF_8000_0001, 6'b100000, 1'b1, 64'h7FF0_0000_0020_0000},
    '{2'd0, 64'hFFFF_FFFF_3F80_0000, 6'b000001, 1'b1, 64'h0000_0000_3F80_0000}
  };

  function automatic logic [63:0] canon_of(input logic [1:0] f);
    case (f)
      2'd0:    return 64'h0000_0000_7FFF_FFFF;
      2'd2:    return 64'h7FFF_FFFF_FFE0_0000;
      default: return 64'h7FFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b,
                      input logic two, input logic clr);
    @(negedge clk);
    fmt = f; op_a = a; op_b = b; two_ops = two; in_valid = 1; sticky_clr = clr;
    @(negedge clk);
    in_valid = 0; sticky_clr = 0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 0, "R11 out_valid", 64'(out_valid), 0);
    chk(in_ready == 1, "R11 in_ready", 64'(in_ready), 1);
    chk(sticky_invalid == 0, "R11 sticky", 64'(sticky_invalid), 0);
    rst_n = 1;

    // R1 R2 R3 R4 R5 R6 R7: table walk, single operand
    for (int i = 0; i < NV; i++) begin
      logic nan_e, inv_e;
      nan_e = VT[i].cls[4] | VT[i].cls[5];
      inv_e = VT[i].cls[5];
      send(VT[i].f, VT[i].op, 64'h0, 1'b0, 1'b0);
      chk(cls_a == VT[i].cls, "R1/R2/R3 class", 64'(cls_a), 64'(VT[i].cls));
      chk(ibit_a == VT[i].ib, "R2 ibit", 64'(ibit_a), 64'(VT[i].ib));
      chk(store_word == VT[i].st, "R4/R5 store", store_word, VT[i].st);
      chk(nan_out_valid == nan_e, "R6 nan flag", 64'(nan_out_valid), 64'(nan_e));
      chk(invalid_op == inv_e, "R7 invalid", 64'(invalid_op), 64'(inv_e));
      if (nan_e) chk(nan_word == canon_of(VT[i].f), "R6 canon", nan_word, canon_of(VT[i].f));
    end

    // R9 clear after table set the flag
    chk(sticky_invalid == 1, "R9 sticky set", 64'(sticky_invalid), 1);
    @(negedge clk); sticky_clr = 1; @(negedge clk); sticky_clr = 0;
    chk(sticky_invalid == 0, "R9 sticky clear", 64'(sticky_invalid), 0);

    // R7: quiet A, signaling B, both used
    send(2'd0, 64'h7FC0_0000, 64'h7F80_0001, 1'b1, 1'b0);
    chk(invalid_op == 1, "R7 snan on B", 64'(invalid_op), 1);
    chk(nan_out_valid == 1, "R6 nan two ops", 64'(nan_out_valid), 1);
    chk(cls_b == 6'b100000, "R1 class B", 64'(cls_b), 64'h20);

    // R8: B ignored when single operand
    send(2'd1, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1'b0, 1'b1);
    chk(nan_out_valid == 0, "R8 B ignored nan", 64'(nan_out_valid), 0);
    chk(invalid_op == 0, "R8 B ignored inv", 64'(invalid_op), 0);
    chk(cls_b == 6'b100000, "R8 B class reported", 64'(cls_b), 64'h20);
    chk(sticky_invalid == 0, "R8 sticky untouched", 64'(sticky_invalid), 0);

    // R9: set wins over clear in the same cycle, then holds
    send(2'd0, 64'h7F80_0001, 64'h0, 1'b0, 1'b1);
    chk(sticky_invalid == 1, "R9 set priority", 64'(sticky_invalid), 1);
    repeat (4) @(negedge clk);
    chk(sticky_invalid == 1, "R9 sticky holds", 64'(sticky_invalid), 1);

    // R10: back-pressure
    out_ready = 0;
    send(2'd0, 64'h3F80_0000, 64'h0, 1'b0, 1'b0);
    chk(out_valid == 1 && in_ready == 0, "R10 stall ready", 64'(in_ready), 0);
    fmt = 2'd0; op_a = 64'h7F80_0000; in_valid = 1;
    @(negedge clk);
    chk(cls_a == 6'b000001, "R10 held result", 64'(cls_a), 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(cls_a == 6'b001000, "R10 next after release", 64'(cls_a), 8);
    @(negedge clk);
    chk(out_valid == 0, "R10 drained", 64'(out_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule